// File: doc/BRIEF.md
# Buffered SPI Master with Status Flags and Selectable Interrupt

This block is a mode-0 SPI master with a transmit FIFO and a receive FIFO on either side of a single shift register. A host pushes bytes into the transmit FIFO and pops received bytes from the receive FIFO. Both sides use valid/ready strobes. The shift register takes the next byte whenever it is idle and the block is allowed to run. It clocks the byte out on MOSI, most significant bit first, and collects the byte arriving on MISO. When the byte is done, the collected byte goes into the receive FIFO. If the receive FIFO is full at that point, the byte is dropped and a sticky overflow flag is raised.

The block reports its state through status outputs: shifter empty, receive empty, receive full, transmit full, receive overflow, and a count of bytes still waiting to be sent. A 3-bit select input picks one of eight interrupt conditions. Four conditions are events that give a one-cycle pulse. The other four are levels. An enable input switches the block on and hands it the serial pins. A stop-in-idle input freezes shifting while the chip-level idle input is high.

Top module: `spi_buf_master`

## Requirements
- R1: Once reset is released, every status output reads idle: shifter empty and receive empty are 1, and transmit full, receive full, overflow, element count, SCK, MOSI, irq and the pin-enable output are all 0.
- R2: While `enable` is 0, the block does not take the serial pins. `pins_en`, SCK and MOSI are 0, `tx_ready` is 0, so host writes are ignored, and both FIFOs and the overflow flag are cleared. Dropping `enable` in the middle of a byte aborts that byte.
- R3: While `stop_in_idle` and `idle` are both 1, no byte is loaded and SCK does not toggle. Transfers go on normally when `idle` is 1 and `stop_in_idle` is 0.
- R4: Each byte is shifted in SPI mode 0. SCK idles low and has a period of CLK_DIV system clocks. MOSI sends the most significant bit first and changes only on the falling edge. MISO is sampled on the rising edge. The received byte reaches the receive FIFO in order.
- R5: `elem_cnt` equals the number of bytes in the transmit FIFO that have not yet been loaded into the shift register. Its range is 0 to DEPTH.
- R6: `sr_empty` is 1 exactly when no byte is in progress in the shift register.
- R7: `tx_full` and `rx_full` are 1 when their FIFO holds DEPTH bytes. `rx_empty` is 1 when the receive FIFO holds none. `rx_valid`/`rx_data` present the oldest received byte.
- R8: When a byte completes while the receive FIFO is full, that byte is discarded and `rx_ovf` is set. `rx_ovf` stays set until a cycle with `ovf_clr` = 1.
- R9: These `irq_sel` values give a level, registered one cycle after the condition: 111 = transmit FIFO full, 011 = receive FIFO full, 010 = receive FIFO holds at least 3/4 of DEPTH, 001 = receive FIFO not empty.
- R10: Select 100 gives a one-cycle irq pulse for each byte loaded into the shift register. Select 101 gives a one-cycle pulse for each byte whose last bit has been shifted.
- R11: Select 110 pulses once when a load takes the last byte out of the transmit FIFO. Select 000 pulses once when a host read takes the last byte out of the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block on; takes the serial pins |
| stop_in_idle | input | 1 | Freeze shifting while idle is high |
| idle | input | 1 | Chip idle indication |
| irq_sel | input | 3 | Interrupt condition select |
| ovf_clr | input | 1 | Clear the overflow flag |
| tx_valid | input | 1 | Host offers a transmit byte |
| tx_data | input | DATA_W | Transmit byte |
| tx_ready | output | 1 | Transmit FIFO accepts a byte |
| rx_valid | output | 1 | Receive byte available |
| rx_data | output | DATA_W | Oldest received byte |
| rx_ready | input | 1 | Host takes the receive byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| pins_en | output | 1 | Serial pins owned by this block |
| sr_empty | output | 1 | Shift register idle |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| tx_full | output | 1 | Transmit FIFO full |
| rx_ovf | output | 1 | Sticky receive overflow |
| elem_cnt | output | clog2(DEPTH+1) | Bytes waiting to be sent |
| irq | output | 1 | Selected interrupt |

## Verification
The FIFO counts and flags change at the clock edge that accepts a push or pop. The bench drives strobes on the falling clock edge and samples at the next falling edge. A load happens at the first edge on which the shifter is idle and allowed to run. The byte completes 16 × CLK_DIV/2 clocks later. The next load follows one edge after that.

`irq` is a register, so a level condition or an event shows up one sampling point after the cycle in which it occurred. For this reason the bench counts how many cycles irq is high across a whole window rather than testing single cycles. The bench captures the bits on MOSI at each rising SCK edge and shifts its MISO model on each falling edge, so the serial data checks follow the pins and not the internal clock count.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  typedef enum logic [2:0] {
    IRQ_RX_DRAINED  = 3'b000,
    IRQ_RX_AVAIL    = 3'b001,
    IRQ_RX_3Q       = 3'b010,
    IRQ_RX_FULL     = 3'b011,
    IRQ_WORD_LOADED = 3'b100,
    IRQ_XFER_DONE   = 3'b101,
    IRQ_TX_DRAINED  = 3'b110,
    IRQ_TX_FULL     = 3'b111
  } irq_mode_e;
endpackage

// File: rtl/spi_buf_fifo.sv
module spi_buf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        push,
  input  logic [W-1:0]                wdata,
  input  logic                        pop,
  output logic [W-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output logic                        full,
  output logic                        empty,
  output logic                        push_ok,
  output logic                        pop_ok
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign count   = cnt_q;
  assign rdata   = mem[rd_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (clr) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (push_ok) wr_n = bump(wr_q);
      if (pop_ok)  rd_n = bump(rd_q);
      if (push_ok && !pop_ok)      cnt_n = cnt_q + CW'(1);
      else if (pop_ok && !push_ok) cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_q] <= wdata;
  end
endmodule

// File: rtl/spi_buf_shifter.sv
module spi_buf_shifter #(
  parameter int W       = 8,
  parameter int CLK_DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic         load_req,
  input  logic [W-1:0] load_data,
  input  logic         miso,
  output logic         load_ack,
  output logic         done,
  output logic [W-1:0] rx_word,
  output logic         busy,
  output logic         sck,
  output logic         mosi
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = (W > 1) ? $clog2(W) : 1;

  logic          busy_q, busy_n;
  logic          sck_q, sck_n;
  logic          samp_q, samp_n;
  logic [DW-1:0] div_q, div_n;
  logic [BW-1:0] bit_q, bit_n;
  logic [W-1:0]  sr_q, sr_n;
  logic          tick, last;

  assign tick     = busy_q && run && (div_q == DW'(HALF - 1));
  assign last     = (bit_q == BW'(W - 1));
  assign load_ack = !clr && !busy_q && run && load_req;
  assign done     = tick && sck_q && last;
  assign rx_word  = {sr_q[W-2:0], samp_q};
  assign busy     = busy_q;
  assign sck      = sck_q;
  assign mosi     = busy_q & sr_q[W-1];

  always_comb begin
    busy_n = busy_q;
    sck_n  = sck_q;
    samp_n = samp_q;
    div_n  = div_q;
    bit_n  = bit_q;
    sr_n   = sr_q;
    if (clr) begin
      busy_n = 1'b0;
      sck_n  = 1'b0;
      div_n  = '0;
      bit_n  = '0;
    end else if (load_ack) begin
      busy_n = 1'b1;
      sck_n  = 1'b0;
      div_n  = '0;
      bit_n  = '0;
      sr_n   = load_data;
    end else if (busy_q && run) begin
      if (tick) begin
        div_n = '0;
        sck_n = !sck_q;
        if (!sck_q) begin
          samp_n = miso;
        end else begin
          sr_n  = rx_word;
          bit_n = bit_q + BW'(1);
          if (last) busy_n = 1'b0;
        end
      end else begin
        div_n = div_q + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      samp_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sr_q   <= '0;
    end else begin
      busy_q <= busy_n;
      sck_q  <= sck_n;
      samp_q <= samp_n;
      div_q  <= div_n;
      bit_q  <= bit_n;
      sr_q   <= sr_n;
    end
  end
endmodule

// File: rtl/spi_buf_irq.sv
module spi_buf_irq
  import spi_buf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  irq_mode_e                  mode,
  input  logic [$clog2(DEPTH+1)-1:0] tx_cnt,
  input  logic [$clog2(DEPTH+1)-1:0] rx_cnt,
  input  logic                       tx_push,
  input  logic                       rx_push,
  input  logic                       rx_pop,
  input  logic                       load_ack,
  input  logic                       done,
  output logic                       irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TQ = (3 * DEPTH + 3) / 4;

  logic irq_q, irq_n;
  logic rx_drained, tx_drained;

  assign rx_drained = rx_pop && !rx_push && (rx_cnt == CW'(1));
  assign tx_drained = load_ack && !tx_push && (tx_cnt == CW'(1));

  always_comb begin
    irq_n = 1'b0;
    if (!clr) begin
      case (mode)
        IRQ_RX_DRAINED:  irq_n = rx_drained;
        IRQ_RX_AVAIL:    irq_n = (rx_cnt != '0);
        IRQ_RX_3Q:       irq_n = (rx_cnt >= CW'(TQ));
        IRQ_RX_FULL:     irq_n = (rx_cnt == CW'(DEPTH));
        IRQ_WORD_LOADED: irq_n = load_ack;
        IRQ_XFER_DONE:   irq_n = done;
        IRQ_TX_DRAINED:  irq_n = tx_drained;
        IRQ_TX_FULL:     irq_n = (tx_cnt == CW'(DEPTH));
        default:         irq_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

  assign irq = irq_q;
endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
  import spi_buf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 4,
  parameter int CLK_DIV = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       stop_in_idle,
  input  logic                       idle,
  input  logic [2:0]                 irq_sel,
  input  logic                       ovf_clr,
  input  logic                       tx_valid,
  input  logic [DATA_W-1:0]          tx_data,
  output logic                       tx_ready,
  output logic                       rx_valid,
  output logic [DATA_W-1:0]          rx_data,
  input  logic                       rx_ready,
  output logic                       sck,
  output logic                       mosi,
  input  logic                       miso,
  output logic                       pins_en,
  output logic                       sr_empty,
  output logic                       rx_empty,
  output logic                       rx_full,
  output logic                       tx_full,
  output logic                       rx_ovf,
  output logic [$clog2(DEPTH+1)-1:0] elem_cnt,
  output logic                       irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              clr, run;
  logic              load_ack, done, busy;
  logic [DATA_W-1:0] tx_head, rx_word;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic              tx_empty;
  logic              ovf_q, ovf_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign clr = !enable;
  assign run = enable && !(stop_in_idle && idle);

  spi_buf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i_n), .clr(clr),
    .push(tx_valid && enable), .wdata(tx_data),
    .pop(load_ack), .rdata(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  spi_buf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i_n), .clr(clr),
    .push(done), .wdata(rx_word),
    .pop(rx_ready && enable), .rdata(rx_data),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  spi_buf_shifter #(.W(DATA_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_i_n), .clr(clr), .run(run),
    .load_req(!tx_empty), .load_data(tx_head), .miso(miso),
    .load_ack(load_ack), .done(done), .rx_word(rx_word),
    .busy(busy), .sck(sck), .mosi(mosi)
  );

  spi_buf_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_i_n), .clr(clr),
    .mode(irq_mode_e'(irq_sel)),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_push(tx_push_ok), .rx_push(rx_push_ok), .rx_pop(rx_pop_ok),
    .load_ack(tx_pop_ok), .done(done), .irq(irq)
  );

  always_comb begin
    ovf_n = ovf_q;
    if (clr)                  ovf_n = 1'b0;
    else if (done && rx_full) ovf_n = 1'b1;
    else if (ovf_clr)         ovf_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) ovf_q <= 1'b0;
    else          ovf_q <= ovf_n;
  end

  assign tx_ready = enable && !tx_full;
  assign rx_valid = !rx_empty;
  assign pins_en  = enable;
  assign sr_empty = !busy;
  assign rx_ovf   = ovf_q;
  assign elem_cnt = tx_cnt;
endmodule

// File: rtl/spi_buf_master_chk.sv
module spi_buf_master_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       enable,
  input logic                       stop_in_idle,
  input logic                       idle,
  input logic                       ovf_clr,
  input logic                       tx_ready,
  input logic                       tx_full,
  input logic                       rx_full,
  input logic                       rx_empty,
  input logic                       sr_empty,
  input logic                       sck,
  input logic                       rx_ovf,
  input logic [$clog2(DEPTH+1)-1:0] elem_cnt
);
  // R6
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_empty |-> !sck);

  // R3
  halt_sck_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stop_in_idle && idle) |=> $stable(sck));

  // R2
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sck && sr_empty && rx_empty && !rx_ovf));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !ovf_clr && enable) |=> rx_ovf);

  // R7
  full_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_ready);

  // R7
  rx_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_empty && rx_full));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elem_cnt <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind spi_buf_master spi_buf_master_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .stop_in_idle(stop_in_idle),
  .idle(idle), .ovf_clr(ovf_clr), .tx_ready(tx_ready), .tx_full(tx_full),
  .rx_full(rx_full), .rx_empty(rx_empty), .sr_empty(sr_empty), .sck(sck),
  .rx_ovf(rx_ovf), .elem_cnt(elem_cnt)
);

// File: tb/spi_buf_master_test.sv
module spi_buf_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, stop_in_idle = 1'b0, idle = 1'b0, ovf_clr = 1'b0;
  logic [2:0] irq_sel = 3'b000;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, rx_valid, sck, mosi, miso, pins_en;
  logic sr_empty, rx_empty, rx_full, tx_full, rx_ovf, irq;
  logic [7:0] rx_data;
  logic [2:0] elem_cnt;

  int checks = 0, errors = 0;
  int si = 0, ci = 0, tj = 0, pulses = 0;
  bit log_en = 1'b0, cnt_en = 1'b0;
  logic [7:0] slave_sr = 8'h00, mcap = 8'h00;
  logic [7:0] cap_log [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_buf_master #(.DATA_W(8), .DEPTH(DEPTH), .CLK_DIV(4)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .stop_in_idle(stop_in_idle),
    .idle(idle), .irq_sel(irq_sel), .ovf_clr(ovf_clr), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .sck(sck), .mosi(mosi),
    .miso(miso), .pins_en(pins_en), .sr_empty(sr_empty), .rx_empty(rx_empty),
    .rx_full(rx_full), .tx_full(tx_full), .rx_ovf(rx_ovf),
    .elem_cnt(elem_cnt), .irq(irq)
  );

  function automatic logic [7:0] tw(input int j);
    return 8'(8'hA5 ^ (j * 37));
  endfunction
  function automatic logic [7:0] sw(input int i);
    return 8'(8'h3C + i * 53);
  endfunction

  // slave model: new word per load, shift after each falling SCK edge
  assign miso = slave_sr[7];
  always @(negedge sr_empty) begin
    slave_sr = sw(si);
    si = si + 1;
  end
  always @(negedge sck) slave_sr = slave_sr << 1;
  always @(posedge sck) mcap = {mcap[6:0], mosi};
  always @(posedge sr_empty) if (log_en) begin
    cap_log[ci] = mcap;
    ci = ci + 1;
  end
  always @(negedge clk) if (cnt_en && irq) pulses = pulses + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] w);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = w;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] w);
    @(negedge clk);
    check({req, " rx_valid"}, int'(rx_valid), 1);
    check({req, " rx_data"}, int'(rx_data), int'(w));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_quiet();
    int n = 0;
    @(negedge clk);
    while (!(sr_empty && elem_cnt == 0) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 sr_empty", int'(sr_empty), 1);
    check("R1 rx_empty", int'(rx_empty), 1);
    check("R1 flags", int'({tx_full, rx_full, rx_ovf, sck, mosi, irq}), 0);
    check("R1 elem_cnt", int'(elem_cnt), 0);
    check("R2 pins_en off", int'(pins_en), 0);
    check("R2 tx_ready off", int'(tx_ready), 0);

    // R2 write while disabled is ignored
    push(8'h77);
    stop_in_idle = 1'b1;
    idle = 1'b1;
    irq_sel = 3'b111;
    enable = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 ignored write", int'(elem_cnt), 0);
    check("R2 pins_en on", int'(pins_en), 1);

    // R3 halted: fill the transmit FIFO, nothing moves
    log_en = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      push(tw(tj));
      tj++;
      check("R5 count while halted", int'(elem_cnt), k + 1);
    end
    check("R7 tx_full", int'(tx_full), 1);
    check("R7 tx_ready low when full", int'(tx_ready), 0);
    @(negedge clk);
    check("R9 sel111 level", int'(irq), 1);
    repeat (20) @(negedge clk);
    check("R3 no shift while halted", int'({sck, sr_empty}), 1);

    // R11 select 110 over four loads: one pulse
    irq_sel = 3'b110;
    @(negedge clk);
    pulses = 0;
    cnt_en = 1'b1;
    idle = 1'b0;
    @(negedge clk);
    check("R6 busy after load", int'(sr_empty), 0);
    check("R5 count after load", int'(elem_cnt), DEPTH - 1);
    wait_quiet();
    cnt_en = 1'b0;
    check("R11 sel110 pulses", pulses, 1);
    check("R7 rx_full", int'(rx_full), 1);
    check("R8 no overflow yet", int'(rx_ovf), 0);

    // R9 level modes on the receive side
    irq_sel = 3'b011;
    repeat (2) @(negedge clk);
    check("R9 sel011 full", int'(irq), 1);
    irq_sel = 3'b010;
    repeat (2) @(negedge clk);
    check("R9 sel010 four", int'(irq), 1);
    pop_expect("R4", sw(0));
    @(negedge clk);
    check("R9 sel010 three", int'(irq), 1);
    pop_expect("R4", sw(1));
    @(negedge clk);
    check("R9 sel010 two", int'(irq), 0);
    irq_sel = 3'b001;
    repeat (2) @(negedge clk);
    check("R9 sel001 avail", int'(irq), 1);
    irq_sel = 3'b000;
    @(negedge clk);
    pulses = 0;
    cnt_en = 1'b1;
    pop_expect("R4", sw(2));
    pop_expect("R4", sw(3));
    repeat (3) @(negedge clk);
    cnt_en = 1'b0;
    check("R11 sel000 pulses", pulses, 1);
    check("R7 rx_empty after drain", int'(rx_empty), 1);

    // R8 five bytes into a four-deep receive FIFO, R10 sel101
    irq_sel = 3'b101;
    @(negedge clk);
    pulses = 0;
    cnt_en = 1'b1;
    for (int k = 0; k < DEPTH + 1; k++) begin
      push(tw(tj));
      tj++;
    end
    wait_quiet();
    cnt_en = 1'b0;
    check("R10 sel101 pulses", pulses, DEPTH + 1);
    check("R8 overflow set", int'(rx_ovf), 1);
    repeat (10) @(negedge clk);
    check("R8 overflow sticky", int'(rx_ovf), 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R8 overflow cleared", int'(rx_ovf), 0);
    for (int k = 4; k < 8; k++) pop_expect("R8 kept", sw(k));
    check("R8 discarded", int'(rx_empty), 1);

    // R10 sel100: one pulse per load
    irq_sel = 3'b100;
    @(negedge clk);
    pulses = 0;
    cnt_en = 1'b1;
    push(tw(tj)); tj++;
    push(tw(tj)); tj++;
    wait_quiet();
    cnt_en = 1'b0;
    check("R10 sel100 pulses", pulses, 2);
    pop_expect("R4", sw(9));
    pop_expect("R4", sw(10));

    // R3 idle without stop-in-idle keeps running
    stop_in_idle = 1'b0;
    idle = 1'b1;
    push(tw(tj)); tj++;
    wait_quiet();
    pop_expect("R3 runs in idle", sw(11));
    idle = 1'b0;

    // R4 bits seen on MOSI match every sent byte
    log_en = 1'b0;
    check("R4 capture count", ci, tj);
    for (int k = 0; k < 12; k++) check("R4 mosi byte", int'(cap_log[k]), int'(tw(k)));

    // R2 abort in mid-byte
    push(tw(tj));
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R2 abort idle", int'({sck, mosi, pins_en, tx_ready}), 0);
    check("R2 abort sr_empty", int'(sr_empty), 1);
    check("R2 abort rx_empty", int'(rx_empty), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule